// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC. It decides whether a frame is kept or thrown away by looking only at its destination address. A frame starts with a byte flagged by `rx_sof` and ends with a byte flagged by `rx_eof`. Its first six bytes form the destination address. These bytes are compared against three things: a programmed station address, the all-ones broadcast address, and a 64-entry multicast hash table. Two control bits refine the decision: a promiscuous control accepts every frame, and a hash-enable control switches the table lookup on or off.

The verdict is a single-cycle strobe with an accept flag. It appears one cycle after the sixth byte, so downstream logic can commit or discard the frame while the rest of it is still arriving. When an accepted frame ends, the block also reports how many zero bytes must be appended to bring the frame up to the 60-byte minimum. Configuration is written through a simple write port with a 12-bit byte address and 16-bit data.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, every configuration register holds zero, so reception is disabled. `verdict_valid` and `pad_valid` are low until a frame has been seen.
- R2: While receive-control bit 0 (the enable bit, register at 0x30C) is 0, every frame of six or more bytes gets a drop verdict, whatever the other controls and tables hold.
- R3: With enable set and receive-control bit 6 (promiscuous) set, any destination address is accepted.
- R4: The station address is held in three registers, each carrying two bytes with the earlier byte in bits 15:8:
  - register 0x320 holds bytes 0 and 1;
  - register 0x31C holds bytes 2 and 3;
  - register 0x318 holds bytes 4 and 5.
  
  A destination equal to the station address is accepted. A destination that differs in any single byte is not accepted by this test.
- R5: With enable set, the destination FF:FF:FF:FF:FF:FF is always accepted.
- R6: With enable set and receive-control bit 11 (hash enable) set, a destination that is neither the station address nor broadcast is looked up in the hash table.
  - The CRC is a reflected CRC-32 with polynomial 0xEDB88320. It starts from all ones, takes each byte least significant bit first in arrival order, and has no final inversion.
  - Index bits 31:26 of that CRC form the table index.
  - Index bits 5:4 pick the table register: group 0 at 0x34C, 1 at 0x348, 2 at 0x344, 3 at 0x340.
  - Index bits 3:0 pick the bit within that register.
  - The frame is accepted if and only if the selected bit is 1.
- R7: With hash enable cleared, a destination that is neither station nor broadcast is dropped, even when every table bit is 1.
- R8: For each frame of at least six bytes, `verdict_valid` is high for exactly one cycle: the cycle after the sixth byte is taken.
- R9: When an accepted frame ends, `pad_valid` pulses in the cycle after its last byte. `pad_len` then equals 60 minus the frame length for frames shorter than 60 bytes, and 0 otherwise. Dropped frames produce no pad report.
- R10: A frame that ends before its sixth byte produces neither a verdict nor a pad report. A byte flagged `rx_sof` always restarts capture from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 16 | Configuration write data |
| rx_vld | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Current byte is the first of a frame |
| rx_eof | input | 1 | Current byte is the last of a frame |
| rx_byte | input | 8 | Receive byte |
| verdict_valid | output | 1 | Verdict strobe, one cycle per frame |
| verdict_accept | output | 1 | Frame accepted (qualified by verdict_valid) |
| pad_valid | output | 1 | Pad report strobe at the end of an accepted frame |
| pad_len | output | 6 | Number of zero bytes to append |

## Verification
Some properties are checked by assertions on every cycle:
- a disabled receiver always yields a drop verdict;
- promiscuous mode, a station match and a broadcast destination always yield an accept verdict one cycle after the sixth byte;
- the verdict strobe never lasts two cycles;
- a pad length never exceeds 54;
- a frame already dropped never produces a pad report;
- a start marker restarts the byte count.

Other properties can only be shown by the bench scenarios:
- that the hash index comes from the right CRC bits;
- that each table group sits at its mirrored address;
- the exact pad count for each frame length;
- that frames shorter than six bytes stay silent.

// File: rtl/rxf_pkg.sv
// Shared constants, types and the byte-wide CRC step for the receive
// destination address filter. Assumes byte-addressed 16-bit registers.
package rxf_pkg;

    localparam int unsigned DA_BYTES = 6;
    localparam int unsigned REG_W    = 16;
    localparam int unsigned CFG_AW   = 12;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // Register addresses: offsets that software relies on
    localparam logic [CFG_AW-1:0] A_RXCTL   = 12'h30C;
    localparam logic [CFG_AW-1:0] A_STA_HI  = 12'h320; // bytes 0-1, lower addresses follow
    localparam logic [CFG_AW-1:0] A_HASH_G0 = 12'h34C; // group 0, higher groups at lower addresses

    localparam int unsigned CTL_EN_BIT      = 0;
    localparam int unsigned CTL_PROMISC_BIT = 6;
    localparam int unsigned CTL_HASH_BIT    = 11;

    typedef struct packed {
        logic en;
        logic promisc;
        logic hash_en;
    } rx_ctl_t;

    // One byte of a reflected CRC-32, least significant bit first
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
// Configuration storage: receive control bits, station address words and
// hash table groups. Writes only; unmatched addresses are ignored.
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int unsigned HASH_GROUPS = 4,
    parameter int unsigned TBL_W       = HASH_GROUPS * REG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CFG_AW-1:0]       wr_addr,
    input  logic [REG_W-1:0]        wr_data,
    output rx_ctl_t                 ctl,
    output logic [DA_BYTES*8-1:0]   station,
    output logic [TBL_W-1:0]        hash_tbl
);

    localparam int unsigned STA_REGS = DA_BYTES * 8 / REG_W;

    logic [STA_REGS-1:0][REG_W-1:0]    sta_q;
    logic [HASH_GROUPS-1:0][REG_W-1:0] hsh_q;

    // Receive control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_en && wr_addr == A_RXCTL) begin
            ctl.en      <= wr_data[CTL_EN_BIT];
            ctl.promisc <= wr_data[CTL_PROMISC_BIT];
            ctl.hash_en <= wr_data[CTL_HASH_BIT];
        end
    end

    // Station address words, word w at A_STA_HI - 4*w
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q <= '0;
        end else begin
            for (int w = 0; w < STA_REGS; w++) begin
                if (wr_en && wr_addr == A_STA_HI - CFG_AW'(4 * w)) begin
                    sta_q[w] <= wr_data;
                end
            end
        end
    end

    // Hash table groups, group g at A_HASH_G0 - 4*g
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsh_q <= '0;
        end else begin
            for (int g = 0; g < HASH_GROUPS; g++) begin
                if (wr_en && wr_addr == A_HASH_G0 - CFG_AW'(4 * g)) begin
                    hsh_q[g] <= wr_data;
                end
            end
        end
    end

    // Word 0 carries the earliest address bytes at the top of station
    for (genvar w = 0; w < STA_REGS; w++) begin : g_sta
        assign station[DA_BYTES*8-1-REG_W*w -: REG_W] = sta_q[w];
    end

    assign hash_tbl = hsh_q;

endmodule

// File: rtl/rxf_da_capture.sv
// Tracks frame position, gathers the destination address and runs the CRC
// over it. Assumes bytes outside a frame (no prior start marker) are noise.
module rxf_da_capture
    import rxf_pkg::*;
#(
    parameter int unsigned MIN_FRAME = 60,
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned LW        = $clog2(MIN_FRAME + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_vld,
    input  logic                  byte_sof,
    input  logic                  byte_eof,
    input  logic [7:0]            byte_data,
    output logic                  da_last,
    output logic                  past_da,
    output logic                  frame_end,
    output logic [LW-1:0]         len_now,
    output logic [DA_BYTES*8-1:0] da_now,
    output logic [IDX_W-1:0]      hash_idx
);

    logic                      in_frame;
    logic                      take;
    logic [LW-1:0]             cnt;
    logic [LW-1:0]             pos;
    logic [DA_BYTES*8-9:0]     da_q;
    logic [31:0]               crc_q;
    logic [31:0]               crc_now;

    assign take      = byte_vld && (byte_sof || in_frame);
    assign pos       = byte_sof ? '0 : cnt;
    assign da_last   = take && (pos == LW'(DA_BYTES - 1));
    assign past_da   = take && (pos >= LW'(DA_BYTES));
    assign frame_end = take && byte_eof;
    assign len_now   = (pos >= LW'(MIN_FRAME)) ? LW'(MIN_FRAME) : pos + 1'b1;
    assign crc_now   = crc_byte(byte_sof ? 32'hFFFF_FFFF : crc_q, byte_data);
    assign da_now    = {da_q, byte_data};
    assign hash_idx  = crc_now[31 -: IDX_W];

    // Frame position, address shift register and CRC state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            cnt      <= '0;
            da_q     <= '0;
            crc_q    <= '0;
        end else if (take) begin
            in_frame <= !byte_eof;
            cnt      <= len_now;
            if (pos < LW'(DA_BYTES - 1)) begin
                da_q  <= {da_q[DA_BYTES*8-17:0], byte_data};
                crc_q <= crc_now;
            end
        end
    end

    // R10: a start marker restarts the count at one byte
    a_r10_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_sof) |=> (cnt == LW'(1)));

endmodule

// File: rtl/rxf_match.sv
// Accept decision for a complete destination address. Pure combinational;
// priority: disabled, promiscuous, station, broadcast, hash lookup.
module rxf_match
    import rxf_pkg::*;
#(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned TBL_W = 64
) (
    input  rx_ctl_t               ctl,
    input  logic [DA_BYTES*8-1:0] station,
    input  logic [DA_BYTES*8-1:0] da,
    input  logic [TBL_W-1:0]      hash_tbl,
    input  logic [IDX_W-1:0]      hash_idx,
    output logic                  accept
);

    // Ordered match chain
    always_comb begin
        if (!ctl.en)                 accept = 1'b0;
        else if (ctl.promisc)        accept = 1'b1;
        else if (da == station)      accept = 1'b1;
        else if (&da)                accept = 1'b1;
        else if (ctl.hash_en)        accept = hash_tbl[hash_idx];
        else                         accept = 1'b0;
    end

endmodule

// File: rtl/rx_da_filter.sv
// Receive destination address filter top: registers the verdict one cycle
// after the sixth byte and reports the zero padding for accepted frames.
// Assumes one byte per valid cycle and a synchronous active-low reset.
module rx_da_filter
    import rxf_pkg::*;
#(
    parameter int unsigned MIN_FRAME   = 60,
    parameter int unsigned HASH_GROUPS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [REG_W-1:0]               cfg_wdata,
    input  logic                           rx_vld,
    input  logic                           rx_sof,
    input  logic                           rx_eof,
    input  logic [7:0]                     rx_byte,
    output logic                           verdict_valid,
    output logic                           verdict_accept,
    output logic                           pad_valid,
    output logic [$clog2(MIN_FRAME+1)-1:0] pad_len
);

    localparam int unsigned LW    = $clog2(MIN_FRAME + 1);
    localparam int unsigned TBL_W = HASH_GROUPS * REG_W;
    localparam int unsigned IDX_W = $clog2(TBL_W);

    rx_ctl_t               ctl;
    logic [DA_BYTES*8-1:0] station;
    logic [TBL_W-1:0]      hash_tbl;
    logic                  da_last;
    logic                  past_da;
    logic                  frame_end;
    logic [LW-1:0]         len_now;
    logic [DA_BYTES*8-1:0] da_now;
    logic [IDX_W-1:0]      hash_idx;
    logic                  accept_now;
    logic                  frame_acc;
    logic                  pad_fire;

    rxf_cfg_regs #(.HASH_GROUPS(HASH_GROUPS), .TBL_W(TBL_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .ctl(ctl), .station(station), .hash_tbl(hash_tbl)
    );

    rxf_da_capture #(.MIN_FRAME(MIN_FRAME), .IDX_W(IDX_W), .LW(LW)) i_cap (
        .clk(clk), .rst_n(rst_n), .byte_vld(rx_vld), .byte_sof(rx_sof),
        .byte_eof(rx_eof), .byte_data(rx_byte), .da_last(da_last),
        .past_da(past_da), .frame_end(frame_end), .len_now(len_now),
        .da_now(da_now), .hash_idx(hash_idx)
    );

    rxf_match #(.IDX_W(IDX_W), .TBL_W(TBL_W)) i_match (
        .ctl(ctl), .station(station), .da(da_now), .hash_tbl(hash_tbl),
        .hash_idx(hash_idx), .accept(accept_now)
    );

    assign pad_fire = frame_end && ((da_last && accept_now) || (past_da && frame_acc));

    // Verdict, remembered acceptance and pad report registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
            frame_acc      <= 1'b0;
            pad_valid      <= 1'b0;
            pad_len        <= '0;
        end else begin
            verdict_valid  <= da_last;
            verdict_accept <= da_last && accept_now;
            if (da_last) frame_acc <= accept_now;
            pad_valid      <= pad_fire;
            pad_len        <= pad_fire ? LW'(MIN_FRAME) - len_now : '0;
        end
    end

    // R2: disabled receiver drops
    a_r2_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (da_last && !ctl.en) |=> (verdict_valid && !verdict_accept));

    // R3: promiscuous accepts
    a_r3_promisc_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (da_last && ctl.en && ctl.promisc) |=> (verdict_valid && verdict_accept));

    // R4: station match accepts
    a_r4_station_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (da_last && ctl.en && da_now == station) |=> verdict_accept);

    // R5: broadcast accepts
    a_r5_bcast_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (da_last && ctl.en && (&da_now)) |=> verdict_accept);

    // R8: verdict strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    // R9: pad never exceeds minimum minus address bytes
    a_r9_pad_range: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid |-> (pad_len <= LW'(MIN_FRAME - DA_BYTES)));

    // R9: a dropped frame ends without a pad report
    a_r9_no_pad_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && past_da && !frame_acc) |=> !pad_valid);

endmodule

// File: tb/test_rx_da_filter.sv
// Self-checking bench: sweeps frame lengths, station byte mismatches and
// many hash indices, with expected verdicts computed in the bench.
module test_rx_da_filter;

    localparam int MINF = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rx_vld = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        verdict_valid;
    logic        verdict_accept;
    logic        pad_valid;
    logic [5:0]  pad_len;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_verd = 0, last_acc = 0, verd_cyc = 0;
    int n_pad = 0, last_pad = 0, pad_cyc = 0;

    always #5 clk = ~clk;

    rx_da_filter i_rx_da_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_byte(rx_byte), .verdict_valid(verdict_valid),
        .verdict_accept(verdict_accept), .pad_valid(pad_valid), .pad_len(pad_len)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (verdict_valid) begin
            n_verd++;
            last_acc = verdict_accept;
            verd_cyc = cyc;
        end
        if (pad_valid) begin
            n_pad++;
            last_pad = pad_len;
            pad_cyc  = cyc;
        end
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Reflected CRC-32 computed one bit at a time
    function automatic logic [5:0] hidx(input logic [47:0] da);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ da[40 - 8 * i + b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    task automatic frame(input logic [47:0] da, input int len, input bit exp_acc,
                         input string req);
        int v0, p0, c6, ce;
        v0 = n_verd; p0 = n_pad; c6 = 0; ce = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_vld  = 1'b1;
            rx_sof  = (i == 0);
            rx_eof  = (i == len - 1);
            rx_byte = (i < 6) ? da[47 - 8 * i -: 8] : 8'(i * 3 + 1);
            if (i == 5) c6 = cyc;
            if (i == len - 1) ce = cyc;
        end
        @(negedge clk);
        rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (3) @(negedge clk);
        if (len >= 6) begin
            chk_eq({req, " R8 verdict count"}, n_verd - v0, 1);
            chk_eq({req, " verdict accept"}, last_acc, int'(exp_acc));
            chk_eq({req, " R8 verdict cycle"}, verd_cyc, c6 + 1);
        end else begin
            chk_eq({req, " R10 no verdict"}, n_verd - v0, 0);
        end
        if (len >= 6 && exp_acc) begin
            chk_eq({req, " R9 pad count"}, n_pad - p0, 1);
            chk_eq({req, " R9 pad length"}, last_pad, (len < MINF) ? MINF - len : 0);
            chk_eq({req, " R9 pad cycle"}, pad_cyc, ce + 1);
        end else begin
            chk_eq({req, " R9/R10 no pad"}, n_pad - p0, 0);
        end
    endtask

    localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        report();
    end

    initial begin
        logic [47:0] da;
        logic [5:0]  ix;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs and a disabled receiver after reset
        chk_eq("R1 verdict_valid at reset", verdict_valid, 0);
        chk_eq("R1 pad_valid at reset", pad_valid, 0);
        frame(BCAST, 64, 1'b0, "R1 reset drops broadcast");

        wr(12'h320, 16'h0211);
        wr(12'h31C, 16'h2233);
        wr(12'h318, 16'h4455);
        // R2: promiscuous and hash bits without enable still drop
        wr(12'h30C, 16'h0840);
        frame(BCAST, 64, 1'b0, "R2 disabled broadcast");
        frame(STA, 30, 1'b0, "R2 disabled station");

        wr(12'h30C, 16'h0001);
        frame(STA, 64, 1'b1, "R4 station match");
        for (int p = 0; p < 6; p++) begin
            frame(STA ^ (48'h1 << (40 - 8 * p)), 20, 1'b0, "R4 single byte mismatch");
        end
        frame(BCAST, 64, 1'b1, "R5 broadcast");
        frame(BCAST, 20, 1'b1, "R5 short broadcast");

        // R7: full table without hash enable
        for (int g = 0; g < 4; g++) wr(12'h34C - 12'(4 * g), 16'hFFFF);
        frame(48'h01_00_5E_00_00_01, 40, 1'b0, "R7 hash disabled");

        // R6: one-hot and inverted tables per index
        wr(12'h30C, 16'h0801);
        for (int k = 0; k < 48; k++) begin
            da = {8'h01, 8'h00, 8'h5E, 8'(k), 8'(k * 7), 8'(k * 13 + 5)};
            ix = hidx(da);
            for (int g = 0; g < 4; g++)
                wr(12'h34C - 12'(4 * g), (g == int'(ix[5:4])) ? (16'h1 << ix[3:0]) : 16'h0);
            frame(da, 40, 1'b1, "R6 hash bit set");
            for (int g = 0; g < 4; g++)
                wr(12'h34C - 12'(4 * g), (g == int'(ix[5:4])) ? ~(16'h1 << ix[3:0]) : 16'hFFFF);
            frame(da, 40, 1'b0, "R6 hash bit clear");
        end

        // R3 with length sweep for R9 and R10
        wr(12'h30C, 16'h0041);
        for (int n = 1; n <= 70; n++) begin
            frame({8'h0A, 8'(n), 8'h33, 8'(n * 5), 8'h77, 8'h01}, n, 1'b1, "R3 promiscuous length sweep");
        end
        report();
    end

endmodule